// File: doc/BRIEF.md
# Pulsed Overload Protection Controller

This block decides, cycle by cycle, whether the supply output stage of a line-powering regulator may conduct. An analogue current comparator reports an overload as an asynchronous digital level. The block brings that level into the clock domain and then handles it in one of two ways, chosen by a mode input.

In pulsed mode, an overload cuts the output for a long shed interval. The output is then given back for a probe window that is one tenth as long. If the overload shows up at any time during the probe window, the shed interval starts again. The output returns to normal only after a whole probe window passes with no overload. In clamp mode, the output is never cut. The overload flag simply follows the synchronised comparator.

Both intervals are counted in pulses of an external timebase, so a bench can use short periods. A thermal trip flag with hysteresis and a master enable are combined into the same output enable. The master enable also drives the control for the loop-through bypass switch. That switch closes only while the block is disabled and not overheated.

Top module: `ovp_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `ovl_flag` and `hot_flag` are 0 whatever `ovl_raw` and `hot_trip` do. `out_en` is 0 and `bypass_closed` is 1 while `enable` is 0.
- R2: In pulsed mode (`static_mode`=0), with `enable`=1 and no thermal trip, `ovl_raw` going high is acted on at the third rising edge. At that edge `out_en` drops to 0 and `ovl_flag` rises to 1. At the two edges before it, `out_en` stays 1.
- R3: Once shed, `out_en` stays 0 until the OFF_TICKS-th edge after the shed edge at which `tick` is 1. `out_en` returns to 1 at that edge.
- R4: A probe window lasts ON_TICKS = OFF_TICKS/ON_DIV `tick` edges. If the synchronised overload is seen at any edge in the window, then at the window's last `tick` edge `out_en` drops again and `ovl_flag` stays 1.
- R5: If a probe window passes with no overload seen, `ovl_flag` clears at its last `tick` edge and `out_en` stays 1.
- R6: In clamp mode, an overload never lowers `out_en`. `ovl_flag` rises at the third edge after `ovl_raw` rises and falls at the third edge after it falls.
- R7: When `static_mode` goes to 1 during a shed interval, `out_en` returns to 1 at the next rising edge.
- R8: `hot_trip` high at an edge sets `hot_flag` at that edge. While `hot_flag` is 1, `out_en` is 0 and `bypass_closed` is 0.
- R9: `hot_flag` clears only at an edge where `cool_ok` is 1 and `hot_trip` is 0. Otherwise it holds.
- R10: With `enable`=0, `out_en` is 0 and `bypass_closed` equals the inverse of `hot_flag`. Any pulse cycle is abandoned and `ovl_flag` clears at the next edge. When `enable` returns, operation resumes from the normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse, one cycle wide |
| ovl_raw | input | 1 | Asynchronous overload comparator level |
| enable | input | 1 | Master enable for the output stage |
| static_mode | input | 1 | 1 = clamp mode, 0 = pulsed mode |
| hot_trip | input | 1 | Over-temperature threshold exceeded |
| cool_ok | input | 1 | Junction cooled below release threshold |
| out_en | output | 1 | Output stage may conduct |
| ovl_flag | output | 1 | Overload status flag |
| hot_flag | output | 1 | Thermal shutdown status flag |
| bypass_closed | output | 1 | Close the loop-through bypass switch |

## Verification
The bench counts `tick` edges across a shed interval and across a probe window. An off-by-one counter would give OFF_TICKS±1 or ON_TICKS±1. An overload pulse placed early in a probe window must restart the shed at the window's end, not be missed. A switch to clamp mode in the middle of a shed must re-enable the output on the very next edge, not after the timer runs out. Asserting `hot_trip` together with `cool_ok` shows whether the trip takes priority. Dropping `enable` during a shed shows whether the flag and the cycle are really abandoned.

// File: rtl/ovp_pkg.sv
// Shared types for the pulsed overload protection controller.
package ovp_pkg;

    // Protection phase of the pulse state machine.
    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,  // output conducting, normal operation
        PH_SHED  = 2'd1,  // output cut for the long interval
        PH_PROBE = 2'd2   // output given back for the short retry window
    } ovp_phase_e;

endpackage

// File: rtl/ovp_sync.sv
// Multi-stage synchroniser for one asynchronous level.
// Assumes the input is a slow level (not a pulse shorter than a clock).
module ovp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the input through the register chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ovp_thermal.sv
// Thermal shutdown flag with hysteresis: set by the trip indication,
// cleared only by a separate cool-down indication while not tripped.
// Assumes both inputs are already synchronous to clk.
module ovp_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_trip,
    input  logic cool_ok,
    output logic hot_flag
);

    // Set has priority over release.
    always_ff @(posedge clk) begin
        if (!rst_n)        hot_flag <= 1'b0;
        else if (hot_trip) hot_flag <= 1'b1;
        else if (cool_ok)  hot_flag <= 1'b0;
    end

endmodule

// File: rtl/ovp_window_fsm.sv
// Pulse state machine: in pulsed mode an overload sheds the output for
// OFF_TICKS timebase pulses, then probes for ON_TICKS pulses. Any overload
// seen during a probe restarts the shed at the window's end.
// In clamp mode the phase is held at RUN and the flag mirrors the overload.
// Assumes ovl_s is synchronous and tick is one cycle wide.
module ovp_window_fsm
    import ovp_pkg::*;
#(
    parameter int OFF_TICKS = 900,
    parameter int ON_TICKS  = 90
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       static_mode,
    input  logic       tick,
    input  logic       ovl_s,
    output ovp_phase_e phase,
    output logic       ovl_flag
);

    localparam int CNT_W = $clog2(OFF_TICKS + 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_TICKS - 1);
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);

    logic [CNT_W-1:0] cnt, cnt_d;
    logic             hit, hit_d;
    logic             flag_d;
    ovp_phase_e       phase_d;

    // Next-state, counter and flag decisions.
    always_comb begin
        phase_d = phase;
        cnt_d   = cnt;
        hit_d   = hit;
        flag_d  = ovl_flag;
        if (!active) begin
            phase_d = PH_RUN;
            cnt_d   = '0;
            hit_d   = 1'b0;
            flag_d  = 1'b0;
        end else if (static_mode) begin
            phase_d = PH_RUN;
            cnt_d   = '0;
            hit_d   = 1'b0;
            flag_d  = ovl_s;
        end else begin
            case (phase)
                PH_RUN: begin
                    flag_d = ovl_s;
                    if (ovl_s) begin
                        phase_d = PH_SHED;
                        cnt_d   = '0;
                    end
                end
                PH_SHED: begin
                    if (tick) begin
                        if (cnt == OFF_LAST) begin
                            phase_d = PH_PROBE;
                            cnt_d   = '0;
                            hit_d   = 1'b0;
                        end else begin
                            cnt_d = cnt + 1'b1;
                        end
                    end
                end
                PH_PROBE: begin
                    hit_d = hit | ovl_s;
                    if (tick) begin
                        if (cnt == ON_LAST) begin
                            cnt_d = '0;
                            hit_d = 1'b0;
                            if (hit | ovl_s) begin
                                phase_d = PH_SHED;
                            end else begin
                                phase_d = PH_RUN;
                                flag_d  = 1'b0;
                            end
                        end else begin
                            cnt_d = cnt + 1'b1;
                        end
                    end
                end
                default: phase_d = PH_RUN;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_RUN;
            cnt      <= '0;
            hit      <= 1'b0;
            ovl_flag <= 1'b0;
        end else begin
            phase    <= phase_d;
            cnt      <= cnt_d;
            hit      <= hit_d;
            ovl_flag <= flag_d;
        end
    end

endmodule

// File: rtl/ovp_ctrl.sv
// Top of the pulsed overload protection controller. Combines the pulse
// state machine, the thermal flag and the master enable into the output
// enable and the bypass switch control.
// Assumes tick, enable, static_mode, hot_trip and cool_ok are synchronous.
module ovp_ctrl
    import ovp_pkg::*;
#(
    parameter int OFF_TICKS   = 900,
    parameter int ON_DIV      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ovl_raw,
    input  logic enable,
    input  logic static_mode,
    input  logic hot_trip,
    input  logic cool_ok,
    output logic out_en,
    output logic ovl_flag,
    output logic hot_flag,
    output logic bypass_closed
);

    localparam int ON_RAW   = OFF_TICKS / ON_DIV;
    localparam int ON_TICKS = (ON_RAW > 0) ? ON_RAW : 1;

    logic       ovl_s;
    logic       active;
    ovp_phase_e phase;

    ovp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ovl_raw),
        .q     (ovl_s)
    );

    ovp_thermal u_thermal (
        .clk      (clk),
        .rst_n    (rst_n),
        .hot_trip (hot_trip),
        .cool_ok  (cool_ok),
        .hot_flag (hot_flag)
    );

    // Protection runs only when enabled and not overheated.
    assign active = enable & ~hot_flag;

    ovp_window_fsm #(.OFF_TICKS(OFF_TICKS), .ON_TICKS(ON_TICKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .static_mode (static_mode),
        .tick        (tick),
        .ovl_s       (ovl_s),
        .phase       (phase),
        .ovl_flag    (ovl_flag)
    );

    // Output conducts unless disabled, overheated or shedding.
    assign out_en        = active & (phase != PH_SHED);
    // Bypass closes only in standby; overheating forces it open.
    assign bypass_closed = ~enable & ~hot_flag;

endmodule

// File: rtl/ovp_ctrl_chk.sv
// Checker for ovp_ctrl, bound to every instance of the top module.
module ovp_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic static_mode,
    input logic hot_trip,
    input logic cool_ok,
    input logic out_en,
    input logic ovl_flag,
    input logic hot_flag,
    input logic bypass_closed
);

    assert_hot_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hot_trip |=> hot_flag);

    assert_hot_shut_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hot_flag |-> (!out_en && !bypass_closed));

    assert_hot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_flag && !cool_ok) |=> hot_flag);

    assert_clamp_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && static_mode && $past(static_mode) && !hot_flag) |-> out_en);

    assert_clear_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ovl_flag) && enable && !hot_flag) |-> out_en);

    assert_dis_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !ovl_flag);

    assert_dis_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> !bypass_closed);

endmodule

bind ovp_ctrl ovp_ctrl_chk u_ovp_ctrl_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .static_mode   (static_mode),
    .hot_trip      (hot_trip),
    .cool_ok       (cool_ok),
    .out_en        (out_en),
    .ovl_flag      (ovl_flag),
    .hot_flag      (hot_flag),
    .bypass_closed (bypass_closed)
);

// File: tb/test_ovp_ctrl.sv
// Bench for ovp_ctrl: directed corner cases plus seeded random stimulus,
// compared every cycle against a behavioural model built from the brief.
module test_ovp_ctrl;

    localparam int OFF_T = 20;
    localparam int ON_T  = 2;

    logic clk = 1'b0;
    logic rst_n, tick, ovl_raw, enable, static_mode, hot_trip, cool_ok;
    logic out_en, ovl_flag, hot_flag, bypass_closed;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;

    // 250 MHz clock.
    always #2 clk = ~clk;

    ovp_ctrl #(.OFF_TICKS(OFF_T), .ON_DIV(10), .SYNC_STAGES(2)) i_ovp_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ovl_raw(ovl_raw),
        .enable(enable), .static_mode(static_mode), .hot_trip(hot_trip),
        .cool_ok(cool_ok), .out_en(out_en), .ovl_flag(ovl_flag),
        .hot_flag(hot_flag), .bypass_closed(bypass_closed)
    );

    // Timebase: one pulse every third cycle, changed on falling edges.
    initial begin
        int div = 0;
        tick = 1'b0;
        forever begin
            @(negedge clk);
            div  = (div == 2) ? 0 : div + 1;
            tick = (div == 0);
        end
    end

    // Behavioural model state.
    logic m_s1, m_s2, m_hot, m_hit, m_flag;
    int   m_ph, m_cnt;

    // Model update from the requirements (0 run, 1 shed, 2 probe).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_hot <= 0; m_hit <= 0; m_flag <= 0;
            m_ph <= 0; m_cnt <= 0;
        end else begin
            m_s1 <= ovl_raw;
            m_s2 <= m_s1;
            if (hot_trip) m_hot <= 1'b1;
            else if (cool_ok) m_hot <= 1'b0;
            if (!(enable && !m_hot)) begin
                m_ph <= 0; m_cnt <= 0; m_hit <= 0; m_flag <= 0;
            end else if (static_mode) begin
                m_ph <= 0; m_cnt <= 0; m_hit <= 0; m_flag <= m_s2;
            end else if (m_ph == 0) begin
                m_flag <= m_s2;
                if (m_s2) begin m_ph <= 1; m_cnt <= 0; end
            end else if (m_ph == 1) begin
                if (tick) begin
                    if (m_cnt == OFF_T - 1) begin m_ph <= 2; m_cnt <= 0; m_hit <= 0; end
                    else m_cnt <= m_cnt + 1;
                end
            end else begin
                m_hit <= m_hit | m_s2;
                if (tick) begin
                    if (m_cnt == ON_T - 1) begin
                        m_cnt <= 0; m_hit <= 0;
                        if (m_hit | m_s2) m_ph <= 1;
                        else begin m_ph <= 0; m_flag <= 0; end
                    end else m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (chk_on) begin
            chk("R3", "model out_en", out_en, enable && !m_hot && (m_ph != 1));
            chk("R4", "model ovl_flag", ovl_flag, m_flag);
            chk("R9", "model hot_flag", hot_flag, m_hot);
            chk("R10", "model bypass_closed", bypass_closed, !enable && !m_hot);
        end
    end

    // Count tick edges until an output reaches a value (0 = out_en, 1 = ovl_flag).
    task automatic count_ticks(input int which, input logic val, output int n);
        n = 0;
        for (int k = 0; k < 500; k++) begin
            @(posedge clk);
            if (tick) n++;
            #1;
            if (((which == 0) ? out_en : ovl_flag) === val) break;
        end
    endtask

    task automatic finish_sim;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual hung expected finished");
        finish_sim();
    end

    initial begin
        int n;
        void'($urandom(32'd2024));
        rst_n = 0; ovl_raw = 1; enable = 0; static_mode = 0; hot_trip = 1; cool_ok = 0;

        // R1: reset dominates the overload and thermal inputs.
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset ovl_flag", ovl_flag, 1'b0);
        chk("R1", "reset hot_flag", hot_flag, 1'b0);
        chk("R1", "reset out_en", out_en, 1'b0);
        chk("R1", "reset bypass_closed", bypass_closed, 1'b1);
        @(negedge clk);
        ovl_raw = 0; hot_trip = 0;
        @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        chk("R1", "first edge ovl_flag", ovl_flag, 1'b0);
        chk("R1", "first edge hot_flag", hot_flag, 1'b0);
        chk_on = 1'b1;
        @(negedge clk);
        enable = 1;
        repeat (4) @(posedge clk);

        // R2: third edge after the raw overload sheds the output.
        @(negedge clk);
        ovl_raw = 1;
        @(posedge clk); #1; chk("R2", "edge1 out_en", out_en, 1'b1);
        @(posedge clk); #1; chk("R2", "edge2 out_en", out_en, 1'b1);
        @(posedge clk); #1;
        chk("R2", "edge3 out_en", out_en, 1'b0);
        chk("R2", "edge3 ovl_flag", ovl_flag, 1'b1);
        @(negedge clk);
        ovl_raw = 0;

        // R3: shed lasts OFF_T tick edges.
        count_ticks(0, 1'b1, n);
        chk_int("R3", "shed tick count", n, OFF_T);

        // R5: clean probe window clears the flag after ON_T ticks.
        count_ticks(1, 1'b0, n);
        chk_int("R5", "clean probe tick count", n, ON_T);
        chk("R5", "out_en after clean probe", out_en, 1'b1);

        // R4: overload inside the probe window restarts the shed.
        @(negedge clk); ovl_raw = 1;
        repeat (3) @(posedge clk); #1;
        chk("R2", "second shed out_en", out_en, 1'b0);
        @(negedge clk); ovl_raw = 0;
        count_ticks(0, 1'b1, n);
        chk_int("R3", "second shed tick count", n, OFF_T);
        @(negedge clk); ovl_raw = 1;
        @(negedge clk); ovl_raw = 0;
        count_ticks(0, 1'b0, n);
        chk_int("R4", "dirty probe tick count", n, ON_T);
        chk("R4", "ovl_flag kept after dirty probe", ovl_flag, 1'b1);

        // R7: clamp mode mid-shed re-enables on the next edge.
        repeat (4) @(posedge clk);
        @(negedge clk); static_mode = 1;
        @(posedge clk); #1;
        chk("R7", "out_en after mode switch", out_en, 1'b1);
        chk("R7", "ovl_flag after mode switch", ovl_flag, 1'b0);

        // R6: clamp mode flag follows the overload, output stays on.
        @(negedge clk); ovl_raw = 1;
        @(posedge clk); #1; chk("R6", "clamp edge1 flag", ovl_flag, 1'b0);
        @(posedge clk); #1; chk("R6", "clamp edge2 flag", ovl_flag, 1'b0);
        @(posedge clk); #1;
        chk("R6", "clamp edge3 flag", ovl_flag, 1'b1);
        chk("R6", "clamp out_en", out_en, 1'b1);
        repeat (8) @(posedge clk); #1;
        chk("R6", "clamp out_en held", out_en, 1'b1);
        @(negedge clk); ovl_raw = 0;
        repeat (2) @(posedge clk); #1;
        chk("R6", "clamp release edge2 flag", ovl_flag, 1'b1);
        @(posedge clk); #1;
        chk("R6", "clamp release edge3 flag", ovl_flag, 1'b0);

        // R8 and R9: thermal trip and hysteresis.
        @(negedge clk); static_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); hot_trip = 1;
        @(posedge clk); #1;
        chk("R8", "hot_flag after trip", hot_flag, 1'b1);
        chk("R8", "out_en when hot", out_en, 1'b0);
        chk("R8", "bypass open when hot", bypass_closed, 1'b0);
        @(negedge clk); hot_trip = 0;
        repeat (5) @(posedge clk); #1;
        chk("R9", "hot_flag held without cool_ok", hot_flag, 1'b1);
        @(negedge clk); hot_trip = 1; cool_ok = 1;
        @(posedge clk); #1;
        chk("R9", "trip wins over cool_ok", hot_flag, 1'b1);
        @(negedge clk); hot_trip = 0;
        @(posedge clk); #1;
        chk("R9", "hot_flag cleared by cool_ok", hot_flag, 1'b0);
        chk("R9", "out_en after cool-down", out_en, 1'b1);
        @(negedge clk); cool_ok = 0;

        // R10: disabling mid-shed abandons the cycle.
        @(negedge clk); ovl_raw = 1;
        repeat (3) @(posedge clk); #1;
        chk("R2", "shed before disable", out_en, 1'b0);
        @(negedge clk); ovl_raw = 0;
        @(negedge clk); enable = 0;
        #1;
        chk("R10", "out_en disabled", out_en, 1'b0);
        chk("R10", "bypass closed disabled", bypass_closed, 1'b1);
        @(posedge clk); #1;
        chk("R10", "ovl_flag cleared by disable", ovl_flag, 1'b0);
        @(negedge clk); enable = 1;
        #1;
        chk("R10", "out_en on re-enable", out_en, 1'b1);
        @(posedge clk); #1;
        chk("R10", "out_en after re-enable edge", out_en, 1'b1);
        chk("R10", "ovl_flag after re-enable", ovl_flag, 1'b0);

        // Seeded random stimulus, checked against the model every cycle.
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 99) < 6)   ovl_raw = ~ovl_raw;
            if ($urandom_range(0, 149) == 0) enable = ~enable;
            if ($urandom_range(0, 299) == 0) static_mode = ~static_mode;
            hot_trip = ($urandom_range(0, 399) == 0);
            cool_ok  = ($urandom_range(0, 19) == 0);
        end
        repeat (3) @(posedge clk);
        #2;
        finish_sim();
    end

endmodule